// File: doc/BRIEF.md
# Self-Correcting Ring Counter

This block is a one-hot ring counter that repairs itself. A single set bit moves one place toward the least significant position on each enabled clock edge. When it leaves bit 0 it wraps round to the most significant position.

In the default build the top output bit is not a flip-flop. It is formed as the NOR of the stored lower bits. While any stored bit is set, zeros flow into the stored chain. A one enters only once the chain is empty. Any corrupted value therefore drains back into the legal cycle within a few enabled clocks, with no reset needed.

A build-time parameter selects a plain circular rotate register instead, for side-by-side comparison. A flag output reports whether the present value is a legal one-hot code, so the recovery time after a corruption can be measured at the ports.

Top module: `ring_sc_counter`

## Requirements
- R1: While reset is asserted, and after it is released, the output shows only its most significant bit set (1000 for WIDTH=4) until the first enabled edge.
- R2: From a legal value, each rising clock edge with `en` high shifts the single set bit one position toward bit 0; bit 0 wraps to bit WIDTH-1 (1000, 0100, 0010, 0001, 1000).
- R3: With `en` low, a clock edge leaves the output unchanged, whether the value is legal or not.
- R4: `legal_o` is 1 exactly when `cnt_o` has one bit set; it is 0 for the all-zero value and for values with two or more bits set.
- R5: With ROBUST=1, only WIDTH-1 bits are stored. Output bit WIDTH-1 is the NOR of those bits, so `cnt_o` is never all-zero. Each enabled edge shifts the stored bits toward bit 0, with the current top output bit entering at the top.
- R6: With ROBUST=1, a stored corruption showing 0110 becomes 0011 after one enabled edge and 0001 after the next.
- R7: With ROBUST=1, any stored value gives a legal output within WIDTH-1 enabled edges. Once legal, the output stays legal.
- R8: With ROBUST=0, all WIDTH bits are flip-flops in a circular rotate. An illegal value keeps rotating among illegal values: 1100 goes to 0110, then 0011, then 1001, then 1100.
- R9: The stored bits sit in one variable, `state_q`, in instance `u_core` of generate block `g_robust` (ROBUST=1) or `g_plain` (ROBUST=0). This lets a simulation force any stored pattern; after release the counter continues from that pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Count enable; the stored bits hold when low |
| cnt_o | output | WIDTH | One-hot count value |
| legal_o | output | 1 | High when `cnt_o` has exactly one bit set |

## Verification
Every cycle, the assertions check four things:
- the flag agrees with a population count of the output;
- a legal value with enable high rotates by one place;
- a disabled edge leaves the output unchanged;
- a legal value never turns illegal.

For the robust build, they also check that the output is never all-zero and that a counter of enabled illegal edges never passes WIDTH-2.

Only the bench's scenarios can show the exact drain sequences after a forced corruption. The same holds for the endless illegal cycling of the plain build and the reset value seen while reset is held.

// File: rtl/ring_pkg.sv
package ring_pkg;

    localparam int unsigned RING_MAX_WIDTH = 64;

    // Number of set bits in a vector of up to RING_MAX_WIDTH bits.
    function automatic int unsigned ring_popcount(logic [RING_MAX_WIDTH-1:0] vec);
        int unsigned total;
        total = 0;
        for (int i = 0; i < RING_MAX_WIDTH; i++) begin
            total += int'(vec[i]);
        end
        return total;
    endfunction

endpackage

// File: rtl/ring_onehot_flag.sv
module ring_onehot_flag #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] vec_i,
    output logic             legal_o
);
    import ring_pkg::*;

    always_comb begin
        legal_o = (ring_popcount(RING_MAX_WIDTH'(vec_i)) == 1);
    end

endmodule

// File: rtl/ring_drain_core.sv
// Robust variant: WIDTH-1 stored bits; top output bit is their NOR.
module ring_drain_core #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    output logic [WIDTH-1:0] cnt_o
);
    localparam int SW = WIDTH - 1;

    typedef struct packed {
        logic [SW-1:0] bits;
    } drain_state_t;

    drain_state_t state_d, state_q;
    logic         head;

    always_comb begin
        head    = ~|state_q.bits;
        state_d = state_q;
        if (en) begin
            state_d.bits = SW'({head, state_q.bits} >> 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cnt_o = {head, state_q.bits};

endmodule

// File: rtl/ring_rotate_core.sv
// Plain variant: WIDTH flip-flops in a circular rotate.
module ring_rotate_core #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    output logic [WIDTH-1:0] cnt_o
);
    localparam logic [WIDTH-1:0] RESET_STATE = {1'b1, {(WIDTH-1){1'b0}}};

    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } rot_state_t;

    rot_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (en) begin
            state_d.bits = {state_q.bits[0], state_q.bits[WIDTH-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RESET_STATE;
        end else begin
            state_q <= state_d;
        end
    end

    assign cnt_o = state_q.bits;

endmodule

// File: rtl/ring_sc_counter.sv
module ring_sc_counter #(
    parameter int WIDTH  = 4,
    parameter bit ROBUST = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    output logic [WIDTH-1:0] cnt_o,
    output logic             legal_o
);
    logic [WIDTH-1:0] cnt_w;

    generate
        if (ROBUST) begin : g_robust
            ring_drain_core #(.WIDTH(WIDTH)) u_core (
                .clk   (clk),
                .rst_n (rst_n),
                .en    (en),
                .cnt_o (cnt_w)
            );
        end else begin : g_plain
            ring_rotate_core #(.WIDTH(WIDTH)) u_core (
                .clk   (clk),
                .rst_n (rst_n),
                .en    (en),
                .cnt_o (cnt_w)
            );
        end
    endgenerate

    ring_onehot_flag #(.WIDTH(WIDTH)) u_flag (
        .vec_i   (cnt_w),
        .legal_o (legal_o)
    );

    assign cnt_o = cnt_w;

endmodule

// File: rtl/ring_sc_counter_chk.sv
module ring_sc_counter_chk #(
    parameter int WIDTH  = 4,
    parameter bit ROBUST = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic [WIDTH-1:0] cnt_o,
    input logic             legal_o
);
    localparam int BW = $clog2(WIDTH) + 1;

    // R4: flag matches a population count of the output
    a_r4_flag_match: assert property (@(posedge clk) disable iff (!rst_n)
        legal_o == ($countones(cnt_o) == 1));

    // R2: legal value rotates one place toward bit 0 on an enabled edge
    a_r2_rotate: assert property (@(posedge clk) disable iff (!rst_n)
        (legal_o && en) |=> (cnt_o == {$past(cnt_o[0]), $past(cnt_o[WIDTH-1:1])}));

    // R3: disabled edge holds the value
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(cnt_o));

    // R7: a legal value never becomes illegal
    a_r7_stay_legal: assert property (@(posedge clk) disable iff (!rst_n)
        legal_o |=> legal_o);

    generate
        if (ROBUST) begin : g_robust_chk
            logic [BW-1:0] bad_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    bad_q <= '0;
                end else if (legal_o) begin
                    bad_q <= '0;
                end else if (en && (bad_q < BW'(WIDTH))) begin
                    bad_q <= bad_q + 1'b1;
                end
            end

            // R5: output never all-zero
            a_r5_never_empty: assert property (@(posedge clk) disable iff (!rst_n)
                cnt_o != '0);

            // R7: illegal for no more than WIDTH-2 enabled edges
            a_r7_recover_window: assert property (@(posedge clk) disable iff (!rst_n)
                !legal_o |-> (bad_q <= BW'(WIDTH - 2)));
        end
    endgenerate

endmodule

bind ring_sc_counter ring_sc_counter_chk #(.WIDTH(WIDTH), .ROBUST(ROBUST)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .cnt_o   (cnt_o),
    .legal_o (legal_o)
);

// File: tb/ring_sc_counter_bench.sv
module ring_sc_counter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 4;
    localparam int NVEC = 12;
    // each entry: {en, expected count after the edge}
    localparam logic [4:0] VEC [NVEC] = '{
        5'b1_0100, 5'b1_0010, 5'b0_0010, 5'b1_0001, 5'b1_1000, 5'b0_1000,
        5'b0_1000, 5'b1_0100, 5'b1_0010, 5'b1_0001, 5'b1_1000, 5'b1_0100
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic [W-1:0] rb_cnt, pl_cnt;
    logic rb_legal, pl_legal;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ring_sc_counter #(.WIDTH(W), .ROBUST(1'b1)) u_ring_sc_counter (
        .clk(clk), .rst_n(rst_n), .en(en), .cnt_o(rb_cnt), .legal_o(rb_legal));

    ring_sc_counter #(.WIDTH(W), .ROBUST(1'b0)) u_plain (
        .clk(clk), .rst_n(rst_n), .en(en), .cnt_o(pl_cnt), .legal_o(pl_legal));

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step(input logic en_v);
        en = en_v;
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    // hold reset, force stored patterns, release on deassertion
    task automatic inject(input logic [W-2:0] rb_v, input logic [W-1:0] pl_v);
        @(negedge clk);
        en = 1'b0;
        rst_n = 1'b0;
        force u_ring_sc_counter.g_robust.u_core.state_q = rb_v;
        force u_plain.g_plain.u_core.state_q = pl_v;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        release u_ring_sc_counter.g_robust.u_core.state_q;
        release u_plain.g_plain.u_core.state_q;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        #1;
        check("R1 reset robust", rb_cnt, 4'b1000);
        check("R1 reset plain", pl_cnt, 4'b1000);
        check("R4 reset flag", {3'b0, rb_legal}, 4'b0001);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 after release", rb_cnt, 4'b1000);

        // R2 R3 table walk, both variants share the legal cycle
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][4]);
            check(VEC[i][4] ? "R2 rotate robust" : "R3 hold robust", rb_cnt, VEC[i][3:0]);
            check(VEC[i][4] ? "R2 rotate plain" : "R3 hold plain", pl_cnt, VEC[i][3:0]);
            check("R4 legal flag", {3'b0, rb_legal}, 4'b0001);
        end

        // R6 R8 R9: 0110 drain and 1100 endless cycle
        inject(3'b110, 4'b1100);
        check("R9 forced robust", rb_cnt, 4'b0110);
        check("R4 illegal flag", {3'b0, rb_legal}, 4'b0000);
        check("R9 forced plain", pl_cnt, 4'b1100);
        step(1'b1);
        check("R6 first step", rb_cnt, 4'b0011);
        check("R8 plain step1", pl_cnt, 4'b0110);
        step(1'b1);
        check("R6 second step", rb_cnt, 4'b0001);
        check("R4 recovered flag", {3'b0, rb_legal}, 4'b0001);
        check("R8 plain step2", pl_cnt, 4'b0011);
        step(1'b1);
        check("R7 stays legal", rb_cnt, 4'b1000);
        check("R8 plain step3", pl_cnt, 4'b1001);
        step(1'b1);
        check("R8 plain back to 1100", pl_cnt, 4'b1100);
        check("R8 plain flag low", {3'b0, pl_legal}, 4'b0000);

        // R3 hold on illegal value, then R7 drain from 0111
        inject(3'b111, 4'b1010);
        check("R5 forced top bit low", rb_cnt, 4'b0111);
        step(1'b0);
        check("R3 hold illegal robust", rb_cnt, 4'b0111);
        check("R3 hold illegal plain", pl_cnt, 4'b1010);
        step(1'b1);
        check("R5 drain step", rb_cnt, 4'b0011);
        check("R8 plain 0101", pl_cnt, 4'b0101);
        step(1'b1);
        check("R7 legal within window", rb_cnt, 4'b0001);

        // R7 from 0101; R4 all-zero on plain
        inject(3'b101, 4'b0000);
        check("R4 zero flag plain", {3'b0, pl_legal}, 4'b0000);
        step(1'b1);
        check("R7 one-step recovery", rb_cnt, 4'b0010);
        check("R8 plain zero stays", pl_cnt, 4'b0000);

        // R5: empty stored chain yields top bit
        inject(3'b011, 4'b1111);
        step(1'b1);
        check("R5 drain 0011", rb_cnt, 4'b0001);
        step(1'b1);
        check("R5 NOR injects top", rb_cnt, 4'b1000);
        check("R4 all-ones flag plain", {3'b0, pl_legal}, 4'b0000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule